// File: doc/BRIEF.md
# Gain Step Detector with Dwell Timer

This block sits after a sampling converter and tells an external variable-gain stage when to step its gain. Each valid signed sample is reduced to a magnitude. That magnitude is compared against two programmable thresholds.

Crossing the upper threshold requests a gain decrease on the next clock. A gain increase is requested only after the signal has stayed quiet, below the lower threshold, for a full programmable dwell period counted in clock cycles. Any loud sample restarts that wait. The result is asymmetric, hysteretic gain-step signalling: fast to back off and slow to boost.

The dwell period is held in a 16-bit register. Software writes it one byte at a time through a byte-select write strobe. Each write restarts the dwell count.

The decision logic is a three-state machine:
- `ST_SETTLE`: the dwell counter runs and both outputs are low.
- `ST_RAISE`: the dwell period has expired while quiet, and `gain_inc` is high.
- `ST_OVER`: an overrange sample was seen, `gain_dec` is high and the counter is held at its reload value.

The transitions are:
- SETTLE to RAISE: the counter reaches 1 with no loud sample and no dwell write.
- SETTLE or RAISE to OVER: a valid sample with magnitude above the upper threshold arrives.
- RAISE to SETTLE: a valid sample at or above the lower threshold arrives, or the dwell register is written.
- OVER to SETTLE: a valid sample at or below the upper threshold arrives.
- Reset: the machine enters SETTLE.

Top module: `gain_step_detector`

## Requirements
- R1: The magnitude of a 14-bit two's-complement sample is its absolute value in 13 bits. The code -8192 saturates to 8191, and -8191 gives 8191.
- R2: A valid sample whose magnitude is strictly greater than `upper_thr` drives `gain_dec` high after the next rising clock edge. A magnitude equal to `upper_thr` does not.
- R3: `gain_dec` stays high through cycles with `smp_valid` low. It goes low after the edge that takes the first valid sample with magnitude at or below `upper_thr`.
- R4: Let the dwell counter be reloaded at edge E with effective dwell D. If no loud sample arrives and no write occurs at edges E+1 through E+D, `gain_inc` is high after edge E+D and low before it. Cycles with `smp_valid` low count toward the dwell.
- R5: A valid sample whose magnitude is greater than or equal to `lower_thr` reloads the dwell counter and drives `gain_inc` low after that edge.
- R6: Once high, `gain_inc` stays high for as long as no loud sample arrives and no write occurs.
- R7: `gain_inc` and `gain_dec` are never high together. While `gain_dec` is high the dwell counter does not run. The sample that clears `gain_dec` reloads the counter, so a full dwell follows.
- R8: A write with `dwell_sel`=0 replaces dwell bits 7:0, and one with `dwell_sel`=1 replaces bits 15:8. The written value becomes the reload value at the same edge, restarts the count, and drives `gain_inc` low after that edge.
- R9: A dwell value of 0 behaves as a dwell of 1.
- R10: A synchronous active-high reset clears both outputs, sets the dwell register to 16, and loads the counter from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Signed two's-complement sample |
| upper_thr | input | 13 | Overrange magnitude threshold |
| lower_thr | input | 13 | Quiet magnitude threshold |
| dwell_we | input | 1 | Dwell register byte write strobe |
| dwell_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| dwell_wdata | input | 8 | Byte written to the dwell register |
| gain_dec | output | 1 | Request to lower the gain |
| gain_inc | output | 1 | Request to raise the gain |

## Verification
Both outputs are decoded from the state register. Every response to a sample, a write or a reset is therefore visible one full cycle after the edge that takes the stimulus. The bench drives its inputs just after a falling edge and checks the outputs at the next falling edge, which is half a cycle after the edge that updated them. For the dwell, the bench counts edges from the reloading edge. It checks `gain_inc` low after D-1 further edges and high after D, both for short dwells and for 16 and 256.

// File: rtl/gsd_pkg.sv
package gsd_pkg;

    // Decision states of the gain step detector
    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,   // dwell counter running, no request
        ST_RAISE  = 2'd1,   // quiet for the whole dwell: increment request
        ST_OVER   = 2'd2    // overrange seen: decrement request
    } gsd_state_e;

endpackage

// File: rtl/gsd_magnitude.sv
module gsd_magnitude #(
    parameter int SAMPLE_W = 14,
    parameter int MAG_W    = SAMPLE_W - 1
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [MAG_W-1:0]    mag_o
);

    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [MAG_W-1:0] negated;

    // Low bits of the negation are exact for every code except the most negative
    assign negated = ~sample_i[MAG_W-1:0] + 1'b1;

    always_comb begin
        if (sample_i == MOST_NEG) begin
            mag_o = '1;
        end else if (sample_i[SAMPLE_W-1]) begin
            mag_o = negated;
        end else begin
            mag_o = sample_i[MAG_W-1:0];
        end
    end

endmodule

// File: rtl/gsd_dwell_reg.sv
module gsd_dwell_reg #(
    parameter int                  DWELL_W = 16,
    parameter int                  BYTE_W  = 8,
    parameter int                  SEL_W   = 1,
    parameter logic [DWELL_W-1:0]  RST_VAL = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [BYTE_W-1:0]  wdata_i,
    output logic [DWELL_W-1:0] dwell_next_o
);

    localparam int NUM_BYTES = DWELL_W / BYTE_W;

    logic [DWELL_W-1:0] dwell_q;
    logic [DWELL_W-1:0] merged;

    // One byte lane per register slice; the addressed lane takes the write data
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
        assign merged[b*BYTE_W +: BYTE_W] =
            (we_i && (sel_i == SEL_W'(b))) ? wdata_i : dwell_q[b*BYTE_W +: BYTE_W];
    end

    // Value the register holds after this edge, used as the reload value
    assign dwell_next_o = rst ? RST_VAL : merged;

    always_ff @(posedge clk) begin
        dwell_q <= dwell_next_o;
    end

endmodule

// File: rtl/gsd_dwell_timer.sv
module gsd_dwell_timer #(
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [DWELL_W-1:0] load_val_i,
    output logic               expired_o
);

    localparam logic [DWELL_W-1:0] ONE = {{(DWELL_W-1){1'b0}}, 1'b1};

    logic [DWELL_W-1:0] cnt_q;
    logic [DWELL_W-1:0] eff_val;

    // A programmed zero behaves as a dwell of one cycle
    assign eff_val = (load_val_i == '0) ? ONE : load_val_i;

    always_ff @(posedge clk) begin
        if (load_i) begin
            cnt_q <= eff_val;
        end else if (step_i && (cnt_q != ONE)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expired_o = (cnt_q == ONE);

endmodule

// File: rtl/gain_step_detector.sv
module gain_step_detector #(
    parameter int                 SAMPLE_W  = 14,
    parameter int                 MAG_W     = SAMPLE_W - 1,
    parameter int                 DWELL_W   = 16,
    parameter int                 BYTE_W    = 8,
    parameter int                 SEL_W     = $clog2(DWELL_W / BYTE_W),
    parameter logic [DWELL_W-1:0] DWELL_RST = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [MAG_W-1:0]    upper_thr,
    input  logic [MAG_W-1:0]    lower_thr,
    input  logic                dwell_we,
    input  logic [SEL_W-1:0]    dwell_sel,
    input  logic [BYTE_W-1:0]   dwell_wdata,
    output logic                gain_dec,
    output logic                gain_inc
);

    import gsd_pkg::*;

    gsd_state_e         state_q;
    gsd_state_e         state_d;
    logic [MAG_W-1:0]   mag_w;
    logic [DWELL_W-1:0] dwell_next;
    logic               expired;
    logic               fsm_load;
    logic               fsm_step;
    logic               over_s;
    logic               loud_s;
    logic               back_s;

    gsd_magnitude #(
        .SAMPLE_W (SAMPLE_W),
        .MAG_W    (MAG_W)
    ) u_mag (
        .sample_i (smp_data),
        .mag_o    (mag_w)
    );

    gsd_dwell_reg #(
        .DWELL_W (DWELL_W),
        .BYTE_W  (BYTE_W),
        .SEL_W   (SEL_W),
        .RST_VAL (DWELL_RST)
    ) u_dwell_reg (
        .clk          (clk),
        .rst          (rst),
        .we_i         (dwell_we),
        .sel_i        (dwell_sel),
        .wdata_i      (dwell_wdata),
        .dwell_next_o (dwell_next)
    );

    gsd_dwell_timer #(
        .DWELL_W (DWELL_W)
    ) u_timer (
        .clk        (clk),
        .load_i     (fsm_load | rst),
        .step_i     (fsm_step),
        .load_val_i (dwell_next),
        .expired_o  (expired)
    );

    // Sample classification
    assign over_s = smp_valid && (mag_w > upper_thr);
    assign loud_s = smp_valid && (mag_w >= lower_thr);
    assign back_s = smp_valid && !over_s;

    // Next-state and counter control
    always_comb begin
        state_d  = state_q;
        fsm_load = 1'b0;
        fsm_step = 1'b0;
        unique case (state_q)
            ST_SETTLE: begin
                if (over_s) begin
                    state_d  = ST_OVER;
                    fsm_load = 1'b1;
                end else if (loud_s || dwell_we) begin
                    fsm_load = 1'b1;
                end else if (expired) begin
                    state_d  = ST_RAISE;
                end else begin
                    fsm_step = 1'b1;
                end
            end
            ST_RAISE: begin
                if (over_s) begin
                    state_d  = ST_OVER;
                    fsm_load = 1'b1;
                end else if (loud_s || dwell_we) begin
                    state_d  = ST_SETTLE;
                    fsm_load = 1'b1;
                end
            end
            ST_OVER: begin
                fsm_load = 1'b1;
                if (back_s) begin
                    state_d = ST_SETTLE;
                end
            end
            default: begin
                state_d  = ST_SETTLE;
                fsm_load = 1'b1;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SETTLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        gain_dec = (state_q == ST_OVER);
        gain_inc = (state_q == ST_RAISE);
    end

endmodule

// File: rtl/gsd_checker.sv
module gsd_checker #(
    parameter int MAG_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic [MAG_W-1:0] mag,
    input logic [MAG_W-1:0] upper_thr,
    input logic [MAG_W-1:0] lower_thr,
    input logic             dwell_we,
    input logic             gain_dec,
    input logic             gain_inc
);

    // R2
    dec_on_over_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && (mag > upper_thr)) |=> gain_dec);

    // R3
    dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_dec && !smp_valid) |=> gain_dec);

    // R3
    dec_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && (mag <= upper_thr)) |=> !gain_dec);

    // R5
    loud_drops_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && (mag >= lower_thr)) |=> !gain_inc);

    // R4
    inc_rise_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gain_inc) |-> $past(!(smp_valid && (mag >= lower_thr)) && !dwell_we));

    // R7
    no_both_chk: assert property (@(posedge clk) disable iff (rst)
        !(gain_inc && gain_dec));

    // R8
    write_restart_chk: assert property (@(posedge clk) disable iff (rst)
        dwell_we |=> !gain_inc);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!gain_inc && !gain_dec));

endmodule

bind gain_step_detector gsd_checker #(.MAG_W(MAG_W)) u_gsd_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .mag       (mag_w),
    .upper_thr (upper_thr),
    .lower_thr (lower_thr),
    .dwell_we  (dwell_we),
    .gain_dec  (gain_dec),
    .gain_inc  (gain_inc)
);

// File: tb/tb_gain_step_detector.sv
module tb_gain_step_detector;

    logic        clk = 1'b0;
    logic        rst;
    logic        smp_valid;
    logic [13:0] smp_data;
    logic [12:0] upper_thr;
    logic [12:0] lower_thr;
    logic        dwell_we;
    logic [0:0]  dwell_sel;
    logic [7:0]  dwell_wdata;
    logic        gain_dec;
    logic        gain_inc;

    int n_chk  = 0;
    int n_fail = 0;

    gain_step_detector dut (
        .clk         (clk),
        .rst         (rst),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .upper_thr   (upper_thr),
        .lower_thr   (lower_thr),
        .dwell_we    (dwell_we),
        .dwell_sel   (dwell_sel),
        .dwell_wdata (dwell_wdata),
        .gain_dec    (gain_dec),
        .gain_inc    (gain_inc)
    );

    always #5 clk = ~clk;

    // Vector: {valid, sample[13:0], expected dec, expected inc}
    // Thresholds upper 4000, lower 1000, dwell 3, counter freshly reloaded
    localparam logic [16:0] VECS [0:19] = '{
        {1'b1, 14'd100,      1'b0, 1'b0},   // R4 count 3->2
        {1'b1, 14'd100,      1'b0, 1'b0},   // R4 count 2->1
        {1'b1, 14'd100,      1'b0, 1'b1},   // R4 dwell elapsed
        {1'b1, 14'(-500),    1'b0, 1'b1},   // R6 quiet negative sample
        {1'b0, 14'd5000,     1'b0, 1'b1},   // R6 invalid loud value ignored
        {1'b1, 14'd1000,     1'b0, 1'b0},   // R5 equal to lower is loud
        {1'b1, 14'(-999),    1'b0, 1'b0},   // R4 count
        {1'b0, 14'd0,        1'b0, 1'b0},   // R4 invalid cycle counts
        {1'b0, 14'd0,        1'b0, 1'b1},   // R4 elapsed through idle cycles
        {1'b1, 14'd4000,     1'b0, 1'b0},   // R2 equal to upper: no dec, R5 loud
        {1'b1, 14'd4001,     1'b1, 1'b0},   // R2 above upper
        {1'b0, 14'd0,        1'b1, 1'b0},   // R3 hold on invalid
        {1'b1, 14'(-4001),   1'b1, 1'b0},   // R2 negative overrange
        {1'b1, 14'd0,        1'b0, 1'b0},   // R3 clear, R7 reload
        {1'b1, 14'd0,        1'b0, 1'b0},   // R7 full dwell follows
        {1'b1, 14'd0,        1'b0, 1'b0},   // R7
        {1'b1, 14'd0,        1'b0, 1'b1},   // R7 inc after full dwell
        {1'b1, 14'(-8192),   1'b1, 1'b0},   // R1 most negative is overrange
        {1'b1, 14'd8191,     1'b1, 1'b0},   // R2 maximum positive
        {1'b1, 14'(-4000),   1'b0, 1'b0}    // R3 clear at equal magnitude
    };

    task automatic cyc(input logic v, input logic [13:0] d,
                       input logic we, input logic sel, input logic [7:0] wd);
        smp_valid   = v;
        smp_data    = d;
        dwell_we    = we;
        dwell_sel   = sel;
        dwell_wdata = wd;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 14'd0, 1'b0, 1'b0, 8'd0);
    endtask

    task automatic chk(input string req, input logic exp_dec, input logic exp_inc);
        n_chk++;
        if (gain_dec !== exp_dec || gain_inc !== exp_inc) begin
            n_fail++;
            $display("FAIL %s: dec/inc actual %b/%b expected %b/%b",
                     req, gain_dec, gain_inc, exp_dec, exp_inc);
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        upper_thr = 13'd4000;
        lower_thr = 13'd1000;
        idle(3);
        chk("R10 reset clears outputs", 1'b0, 1'b0);
        rst = 1'b0;
        idle(15);
        chk("R10 reset dwell 16, edge 15", 1'b0, 1'b0);
        idle(1);
        chk("R4 reset dwell 16, edge 16", 1'b0, 1'b1);

        // Dwell = 3 via low byte
        cyc(1'b0, 14'd0, 1'b1, 1'b0, 8'd3);
        chk("R8 low byte write restarts", 1'b0, 1'b0);

        for (int i = 0; i < 20; i++) begin
            cyc(VECS[i][16], VECS[i][15:2], 1'b0, 1'b0, 8'd0);
            chk($sformatf("table vector %0d", i), VECS[i][1], VECS[i][0]);
        end

        // Dwell 0 acts as 1
        cyc(1'b0, 14'd0, 1'b1, 1'b0, 8'd0);
        chk("R9 write zero restarts", 1'b0, 1'b0);
        idle(1);
        chk("R9 zero dwell acts as one", 1'b0, 1'b1);

        // High byte: dwell 0x0100
        cyc(1'b0, 14'd0, 1'b1, 1'b1, 8'd1);
        chk("R8 high byte write restarts", 1'b0, 1'b0);
        idle(255);
        chk("R8 dwell 256, edge 255", 1'b0, 1'b0);
        idle(1);
        chk("R8 dwell 256, edge 256", 1'b0, 1'b1);

        // Counter held during overrange
        cyc(1'b0, 14'd0, 1'b1, 1'b1, 8'd0);
        chk("R8 dwell back to 0", 1'b0, 1'b0);
        cyc(1'b1, 14'd4500, 1'b0, 1'b0, 8'd0);
        chk("R2 overrange", 1'b1, 1'b0);
        for (int k = 0; k < 5; k++) begin
            cyc(1'b0, 14'd0, 1'b0, 1'b0, 8'd0);
            chk("R7 no count while dec", 1'b1, 1'b0);
        end
        cyc(1'b1, 14'd0, 1'b0, 1'b0, 8'd0);
        chk("R3 dec clears", 1'b0, 1'b0);
        idle(1);
        chk("R7 dwell after dec", 1'b0, 1'b1);

        // Saturation boundaries
        upper_thr = 13'd8191;
        cyc(1'b1, 14'(-8192), 1'b0, 1'b0, 8'd0);
        chk("R1 -8192 not above 8191", 1'b0, 1'b0);
        upper_thr = 13'd8190;
        cyc(1'b1, 14'(-8192), 1'b0, 1'b0, 8'd0);
        chk("R1 -8192 saturates above 8190", 1'b1, 1'b0);
        cyc(1'b1, 14'd8190, 1'b0, 1'b0, 8'd0);
        chk("R2 equal to upper clears", 1'b0, 1'b0);
        cyc(1'b1, 14'(-8191), 1'b0, 1'b0, 8'd0);
        chk("R1 -8191 gives 8191", 1'b1, 1'b0);

        // Reset mid-run
        rst = 1'b1;
        idle(1);
        chk("R10 reset from overrange", 1'b0, 1'b0);
        rst = 1'b0;
        idle(15);
        chk("R10 dwell restored, edge 15", 1'b0, 1'b0);
        idle(1);
        chk("R10 dwell restored, edge 16", 1'b0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule